// File: doc/BRIEF.md
# Chainable Event Counter Pair

The block holds two 32-bit event counters, an even one and an odd one. Each counter has a value register and an event-type register. The type register picks the input line the counter follows: a memory-access pulse or a cycle pulse. The odd counter can also be given a chain type. With that type it stops following an input line and instead advances once each time the even counter wraps. The pair then behaves as one 64-bit counter, with the even counter holding the low half.

A single global enable gates all counting. Each counter also has its own enable, which is set and cleared through separate write-one masks. A two-bit overflow status records counter wraps and is cleared by writing ones. Software reaches all state through a simple register port: a one-cycle write strobe with an address and data, and an independent combinational read address.

The odd counter's type may be changed while the pair is running. Changing it to chain makes later even-counter wraps carry into the odd counter. Changing it back returns both counters to independent 32-bit operation.

Top module: `evpair_counter`

## Requirements
- R1: After a synchronous active-low reset, every readable register is zero: counters, types, enables, global enable and overflow status.
- R2: A counter advances by one on a clock edge only when all of these hold: the global enable (bit 0 at address 0) is set, its own enable bit is set, and the input line selected by its type sees a pulse. Type 0x13 follows ev_mem and type 0x11 follows ev_cyc. Any other type, including 0x1E on the even counter, counts nothing.
- R3: Without chaining, an even counter at 0xFFFFFFFF that advances wraps to zero and sets overflow status bit 0.
- R4: When the odd type is 0x1E and both counters are enabled, an even-counter wrap adds one to the odd counter and does not set overflow bit 0.
- R5: An odd counter typed 0x1E does not change while the even counter is disabled, even with the global enable set and event pulses arriving.
- R6: When the odd type is 0x1E and the odd counter is disabled, an even-counter wrap sets overflow bit 0 and leaves the odd counter unchanged.
- R7: Register map: 0 control, 1 enable-set, 2 enable-clear, 3 overflow status, 4 even value, 5 odd value, 6 even type, 7 odd type. Enable bit 0 is the even counter and bit 1 is the odd counter. Writing a mask to address 1 sets the enables whose bits are one. Writing a mask to address 2 clears them. Zero bits leave an enable unchanged. Reading address 1 or 2 returns the enable mask.
- R8: Writing ones to address 3 clears those overflow bits, and zero bits leave them unchanged. If a bit is set and cleared on the same edge, the set wins.
- R9: In chained mode, when the odd counter is at 0xFFFFFFFF and receives a carry, it wraps to zero and sets overflow bit 1. This is the 64-bit overflow.
- R10: The odd type can change at run time. A change to 0x1E makes later even-counter wraps carry into the odd counter. A change back to an ordinary type restores overflow bit 0 on even-counter wraps.
- R11: A write to a counter value appears on the next clock. If the write and an increment for that counter fall on the same edge, the written value wins and no wrap or carry is produced from that counter.
- R12: An unchained odd counter counts its own selected input line, and its wrap from 0xFFFFFFFF sets overflow bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 3 | Write address |
| reg_wdata | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| ev_mem | input | 1 | Memory-access event pulse |
| ev_cyc | input | 1 | Cycle event pulse |

## Verification
The hardest condition to reach from the ports is a full 64-bit wrap. Getting there through events alone would take about 2^64 pulses. The stimulus instead loads both value registers close to 0xFFFFFFFF, so a handful of pulses drive the even counter into a wrap whose carry then wraps the odd counter. The random phase keeps most counter writes in the last sixteen values before all-ones. It also switches the odd type among chain, ordinary and unused codes, so that wraps land on edges where the chained mode, the enables and the type have just changed.

// File: rtl/evp_pkg.sv
// evp_pkg: event codes and register addresses shared by the counter pair.
// Assumes an 8-bit type field and a 3-bit register address.
package evp_pkg;
    localparam int unsigned EV_CODE_W = 8;
    localparam logic [EV_CODE_W-1:0] EV_CYCLE = 8'h11;
    localparam logic [EV_CODE_W-1:0] EV_MEMACC = 8'h13;
    localparam logic [EV_CODE_W-1:0] EV_CHAIN = 8'h1E;

    localparam int unsigned REG_AW = 3;
    localparam logic [REG_AW-1:0] A_CTRL = 3'd0;
    localparam logic [REG_AW-1:0] A_ENSET = 3'd1;
    localparam logic [REG_AW-1:0] A_ENCLR = 3'd2;
    localparam logic [REG_AW-1:0] A_OVF = 3'd3;
    localparam logic [REG_AW-1:0] A_CNT0 = 3'd4;
    localparam logic [REG_AW-1:0] A_CNT1 = 3'd5;
    localparam logic [REG_AW-1:0] A_TYPE0 = 3'd6;
    localparam logic [REG_AW-1:0] A_TYPE1 = 3'd7;
endpackage

// File: rtl/evp_evsel.sv
// evp_evsel: decodes a counter's type code into a hit on its selected
// event line. Assumes event pulses last one cycle. Codes that are not
// ordinary sources (chain, unused) give no hit.
module evp_evsel
    import evp_pkg::*;
#(
    parameter int unsigned TYPE_W = EV_CODE_W
) (
    input  logic [TYPE_W-1:0] ev_type,
    input  logic              ev_mem,
    input  logic              ev_cyc,
    output logic              hit
);
    localparam logic [TYPE_W-1:0] CODE_MEM = TYPE_W'(EV_MEMACC);
    localparam logic [TYPE_W-1:0] CODE_CYC = TYPE_W'(EV_CYCLE);

    // Select the event line named by the type code.
    always_comb begin
        hit = ((ev_type == CODE_MEM) && ev_mem) ||
              ((ev_type == CODE_CYC) && ev_cyc);
    end
endmodule

// File: rtl/evp_counter.sv
// evp_counter: one wrapping value register with a software load.
// Assumes the load has priority over an increment on the same edge;
// wrap flags an increment from all-ones that is actually applied.
module evp_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         wrap
);
    // Hold, load or advance the count.
    always_ff @(posedge clk) begin
        if (!rst_n)   value <= '0;
        else if (ld)  value <= ld_val;
        else if (inc) value <= value + 1'b1;
    end

    // Flag an applied increment from the top value.
    always_comb begin
        wrap = inc && !ld && (&value);
    end

    assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (value == '0));

    assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (value == $past(ld_val)));
endmodule

// File: rtl/evpair_counter.sv
// evpair_counter: two event counters; the odd one can chain on the even
// one's wraps to form a 64-bit count. Assumes a single-cycle write port
// and a combinational read port; chaining is decided from the live odd
// type and both enables on the same edge as the wrap.
module evpair_counter
    import evp_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned TYPE_W = EV_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              ev_mem,
    input  logic              ev_cyc
);
    localparam int unsigned NCNT = 2;
    localparam int unsigned PAD_T = CNT_W - TYPE_W;
    localparam int unsigned PAD_M = CNT_W - NCNT;
    localparam logic [TYPE_W-1:0] CODE_CHAIN = TYPE_W'(EV_CHAIN);

    logic                        ctl_e;
    logic [NCNT-1:0]             en_q;
    logic [NCNT-1:0]             ovf_q;
    logic [NCNT-1:0]             ovf_set;
    logic [NCNT-1:0]             ovf_clr;
    logic [NCNT-1:0][TYPE_W-1:0] type_q;
    logic [NCNT-1:0][CNT_W-1:0]  cnt;
    logic [NCNT-1:0]             hit;
    logic [NCNT-1:0]             ld;
    logic [NCNT-1:0]             inc;
    logic [NCNT-1:0]             wrap;
    logic                        chained;
    logic                        carry;

    // One event decoder and one value register per counter.
    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        localparam logic [REG_AW-1:0] MY_ADDR = (i == 0) ? A_CNT0 : A_CNT1;

        evp_evsel #(.TYPE_W(TYPE_W)) u_sel (
            .ev_type (type_q[i]),
            .ev_mem  (ev_mem),
            .ev_cyc  (ev_cyc),
            .hit     (hit[i])
        );

        evp_counter #(.W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (ld[i]),
            .ld_val (reg_wdata),
            .inc    (inc[i]),
            .value  (cnt[i]),
            .wrap   (wrap[i])
        );

        // Decode a software write to this counter's value.
        always_comb begin
            ld[i] = reg_wr && (reg_addr == MY_ADDR);
        end
    end

    // Chain decision, increments and overflow events for this edge.
    always_comb begin
        chained = (type_q[1] == CODE_CHAIN);
        inc[0]  = ctl_e && en_q[0] && hit[0];
        carry   = chained && en_q[1] && wrap[0];
        inc[1]  = ctl_e && en_q[1] && (chained ? wrap[0] : hit[1]);
        ovf_set = {wrap[1], wrap[0] && !carry};
        ovf_clr = (reg_wr && (reg_addr == A_OVF)) ? reg_wdata[NCNT-1:0] : '0;
    end

    // Control, enable, type and overflow status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_e  <= 1'b0;
            en_q   <= '0;
            ovf_q  <= '0;
            type_q <= '0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    A_CTRL:  ctl_e     <= reg_wdata[0];
                    A_ENSET: en_q      <= en_q | reg_wdata[NCNT-1:0];
                    A_ENCLR: en_q      <= en_q & ~reg_wdata[NCNT-1:0];
                    A_TYPE0: type_q[0] <= reg_wdata[TYPE_W-1:0];
                    A_TYPE1: type_q[1] <= reg_wdata[TYPE_W-1:0];
                    default: ;
                endcase
            end
            ovf_q <= (ovf_q & ~ovf_clr) | ovf_set;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (rd_addr)
            A_CTRL:           rd_data = {{(CNT_W-1){1'b0}}, ctl_e};
            A_ENSET, A_ENCLR: rd_data = {{PAD_M{1'b0}}, en_q};
            A_OVF:            rd_data = {{PAD_M{1'b0}}, ovf_q};
            A_CNT0:           rd_data = cnt[0];
            A_CNT1:           rd_data = cnt[1];
            A_TYPE0:          rd_data = {{PAD_T{1'b0}}, type_q[0]};
            default:          rd_data = {{PAD_T{1'b0}}, type_q[1]};
        endcase
    end

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_e && !ld[0]) |=> (cnt[0] == $past(cnt[0])));

    assert_carry_no_ovf0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> !(ovf_q[0] && !$past(ovf_q[0])));

    assert_chain_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chained && !en_q[0] && !ld[1]) |=> $stable(cnt[1]));

    assert_unchained_ovf0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap[0] && !chained) |=> ovf_q[0]);

    assert_enset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_ENSET) |=>
        ((en_q & $past(reg_wdata[NCNT-1:0])) == $past(reg_wdata[NCNT-1:0])));
endmodule

// File: tb/sim_evpair_counter.sv
`timescale 1ns/1ps
module sim_evpair_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        ev_mem = 1'b0;
    logic        ev_cyc = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state built from the requirements.
    logic        m_e;
    logic [1:0]  m_en, m_ovf;
    logic [7:0]  m_t0, m_t1;
    logic [31:0] m_c0, m_c1;

    evpair_counter u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .ev_mem(ev_mem), .ev_cyc(ev_cyc)
    );

    always #10 clk = ~clk;

    function automatic logic sel_hit(input logic [7:0] t, input logic em, input logic ec);
        return (t == 8'h13 && em) || (t == 8'h11 && ec);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        rd_addr = a;
        #0.5;
        v = rd_data;
    endtask

    task automatic compare_all(input string req);
        logic [31:0] v;
        rd(3'd0, v); chk(req, v, {31'b0, m_e});
        rd(3'd1, v); chk(req, v, {30'b0, m_en});
        rd(3'd3, v); chk(req, v, {30'b0, m_ovf});
        rd(3'd4, v); chk(req, v, m_c0);
        rd(3'd5, v); chk(req, v, m_c1);
        rd(3'd6, v); chk(req, v, {24'b0, m_t0});
        rd(3'd7, v); chk(req, v, {24'b0, m_t1});
    endtask

    // One clock: drive inputs, advance the reference, then release the inputs.
    task automatic step(input logic w, input logic [2:0] a, input logic [31:0] d,
                        input logic em, input logic ec);
        logic w0, w1, ch, inc0, inc1, wr0, wr1, carry;
        logic [1:0] clr;
        @(negedge clk);
        reg_wr = w; reg_addr = a; reg_wdata = d; ev_mem = em; ev_cyc = ec;
        w0 = w && a == 3'd4;
        w1 = w && a == 3'd5;
        ch = (m_t1 == 8'h1E);
        inc0 = !w0 && m_e && m_en[0] && sel_hit(m_t0, em, ec);
        wr0 = inc0 && m_c0 == 32'hFFFFFFFF;
        carry = ch && m_en[1] && wr0;
        inc1 = !w1 && m_e && m_en[1] && (ch ? wr0 : sel_hit(m_t1, em, ec));
        wr1 = inc1 && m_c1 == 32'hFFFFFFFF;
        clr = (w && a == 3'd3) ? d[1:0] : 2'b00;
        @(posedge clk);
        #1;
        m_c0 = w0 ? d : (inc0 ? m_c0 + 1 : m_c0);
        m_c1 = w1 ? d : (inc1 ? m_c1 + 1 : m_c1);
        m_ovf = (m_ovf & ~clr) | {wr1, wr0 && !carry};
        if (w) begin
            case (a)
                3'd0: m_e = d[0];
                3'd1: m_en = m_en | d[1:0];
                3'd2: m_en = m_en & ~d[1:0];
                3'd6: m_t0 = d[7:0];
                3'd7: m_t1 = d[7:0];
                default: ;
            endcase
        end
        reg_wr = 0; ev_mem = 0; ev_cyc = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        step(1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic pulses(input int n, input logic em, input logic ec);
        for (int k = 0; k < n; k++) step(1'b0, 3'd0, 32'd0, em, ec);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        @(posedge clk);
        #1;
        m_e = 0; m_en = 0; m_ovf = 0; m_t0 = 0; m_t1 = 0; m_c0 = 0; m_c1 = 0;
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic expect_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    initial begin
        #(20.0 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd1234));
        do_reset();
        compare_all("R1");

        // R7: enable set/clear masks.
        wr(3'd1, 32'h1); expect_reg("R7", 3'd1, 32'h1);
        wr(3'd1, 32'h2); expect_reg("R7", 3'd2, 32'h3);
        wr(3'd2, 32'h1); expect_reg("R7", 3'd1, 32'h2);
        wr(3'd2, 32'h0); expect_reg("R7", 3'd1, 32'h2);

        // R2: ordinary sources, global gate, unused code.
        do_reset();
        wr(3'd6, 32'h13); wr(3'd7, 32'h11); wr(3'd1, 32'h3); wr(3'd0, 32'h1);
        pulses(5, 1, 0); pulses(3, 0, 1);
        expect_reg("R2", 3'd4, 32'd5); expect_reg("R2", 3'd5, 32'd3);
        wr(3'd0, 32'h0); pulses(4, 1, 1);
        expect_reg("R2", 3'd4, 32'd5);
        wr(3'd0, 32'h1); wr(3'd6, 32'h05); pulses(4, 1, 1);
        expect_reg("R2", 3'd4, 32'd5);
        compare_all("R2");

        // R5: chained odd, even disabled.
        do_reset();
        wr(3'd6, 32'h13); wr(3'd7, 32'h1E); wr(3'd1, 32'h2); wr(3'd0, 32'h1);
        pulses(20, 1, 1);
        expect_reg("R5", 3'd5, 32'd0); expect_reg("R5", 3'd4, 32'd0);

        // R6: chained type, odd disabled, even wraps.
        do_reset();
        wr(3'd6, 32'h13); wr(3'd7, 32'h1E); wr(3'd0, 32'h1);
        wr(3'd4, 32'hFFFFFFF0); wr(3'd1, 32'h1);
        pulses(20, 1, 0);
        expect_reg("R6", 3'd4, 32'd4); expect_reg("R6", 3'd5, 32'd0);
        expect_reg("R6", 3'd3, 32'h1);

        // R4 and R10: odd enabled mid-run under chain type.
        do_reset();
        wr(3'd6, 32'h13); wr(3'd7, 32'h1E); wr(3'd0, 32'h1);
        wr(3'd4, 32'hFFFFFFDC); wr(3'd1, 32'h1);
        pulses(20, 1, 0);
        expect_reg("R4", 3'd4, 32'hFFFFFFF0);
        wr(3'd1, 32'h3); pulses(20, 1, 0);
        expect_reg("R4", 3'd5, 32'd1); expect_reg("R4", 3'd3, 32'h0);

        // R10: type switch ordinary -> chain.
        do_reset();
        wr(3'd6, 32'h13); wr(3'd7, 32'h11); wr(3'd0, 32'h1);
        wr(3'd4, 32'hFFFFFFDC); wr(3'd1, 32'h3);
        pulses(20, 1, 0);
        wr(3'd7, 32'h1E); wr(3'd5, 32'h0);
        pulses(20, 1, 0);
        expect_reg("R10", 3'd5, 32'd1); expect_reg("R10", 3'd3, 32'h0);

        // R10: type switch chain -> ordinary.
        do_reset();
        wr(3'd6, 32'h13); wr(3'd7, 32'h1E); wr(3'd0, 32'h1);
        wr(3'd4, 32'hFFFFFFDC); wr(3'd1, 32'h3);
        pulses(20, 1, 0);
        wr(3'd7, 32'h11); pulses(20, 1, 0);
        expect_reg("R10", 3'd3, 32'h1); expect_reg("R10", 3'd5, 32'd0);

        // R9: 64-bit wrap.
        wr(3'd7, 32'h1E); wr(3'd3, 32'h3);
        wr(3'd4, 32'hFFFFFFFF); wr(3'd5, 32'hFFFFFFFF);
        pulses(1, 1, 0);
        expect_reg("R9", 3'd4, 32'd0); expect_reg("R9", 3'd5, 32'd0);
        expect_reg("R9", 3'd3, 32'h2);

        // R8: write-one-to-clear and set priority.
        wr(3'd3, 32'h0); expect_reg("R8", 3'd3, 32'h2);
        wr(3'd3, 32'h2); expect_reg("R8", 3'd3, 32'h0);
        wr(3'd7, 32'h11); wr(3'd4, 32'hFFFFFFFF);
        step(1'b1, 3'd3, 32'h1, 1'b1, 1'b0);
        expect_reg("R8", 3'd3, 32'h1);

        // R11: write beats increment.
        step(1'b1, 3'd4, 32'h100, 1'b1, 1'b0);
        expect_reg("R11", 3'd4, 32'h100);
        pulses(1, 1, 0);
        expect_reg("R11", 3'd4, 32'h101);

        // R12: unchained odd wrap.
        wr(3'd3, 32'h3); wr(3'd5, 32'hFFFFFFFF);
        pulses(1, 0, 1);
        expect_reg("R12", 3'd5, 32'd0); expect_reg("R12", 3'd3, 32'h2);
        compare_all("R12");

        // Random mix with run-time type switching, checked against the reference.
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] d;
            logic [2:0] a;
            logic w;
            w = ($urandom % 10) < 4;
            a = 3'($urandom % 8);
            d = $urandom;
            case (a)
                3'd0: d = {31'b0, ($urandom % 5) != 0};
                3'd4, 3'd5: if (($urandom % 4) != 0) d = 32'hFFFFFFF0 | ($urandom % 16);
                3'd6, 3'd7: case ($urandom % 4)
                                0: d = 32'h13;
                                1: d = 32'h11;
                                2: d = 32'h1E;
                                default: d = 32'h05;
                            endcase
                default: ;
            endcase
            step(w, a, d, 1'($urandom), 1'($urandom));
            compare_all("R10");
        end

        r = 0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule